// File: doc/BRIEF.md
# Array Frame Readout Sequencer

This block schedules the digital side of one frame of readout from a recording array of ROWS by COLS channels, 8 by 16 by default. Each frame begins with a single strobe that makes every channel capture its amplified signal at the same instant. The block then walks through the rows from the first to the last. For each row it drives the row index to the column converters and issues one start pulse that all of them share. When every column has reported done, it sends out the row's results one column per cycle. Each output word carries its row index, its column index and its conversion code.

The block also owns the periodic drift-clearing reset of the amplifier chain. That reset follows a fixed cycle count since reset, and the block places the capture strobe so that it never falls inside a reset. A bank of per-channel gain-mode codes is held here and presented to the analog array as one flat bus. Frames repeat while the frame request input stays high.

Top module: `frame_scan_seq`

## Requirements
- R1: While reset is held, sh_strobe, conv_start and out_valid are 0. Every 3-bit field of gain_bus equals GAIN_INIT, which is 0 by default. drift_rst is 1.
- R2: sh_strobe is a one-cycle pulse. It is raised only while frame_go is high, and it comes before the first conv_start of its frame.
- R3: After a strobe, exactly one one-cycle conv_start is issued per row, in ascending row order from 0 to ROWS-1. row_sel equals that row while conv_start is high.
- R4: After all COLS conv_done bits for a row have been seen, the block emits COLS samples on consecutive cycles, with out_valid high and out_col running 0 to COLS-1. Each sample carries out_row (3 bits), out_col (4 bits) and out_code (8 bits). out_code is the conv_code slice [c*8 +: 8] captured when conv_done[c] was high.
- R5: out_first is 1 on the sample with row 0 and column 0, and 0 on every other sample.
- R6: No new sh_strobe is issued until all ROWS rows of the current frame have been emitted.
- R7: Columns may report done in any order and after different latencies. Each code is still delivered under its own column.
- R8: drift_rst is 1 in exactly those cycles where k mod DRIFT_PERIOD < DRIFT_LEN. Here k is the number of rising clock edges since reset was released.
- R9: sh_strobe is never high in a cycle where drift_rst is high.
- R10: A cycle with gain_we high writes gain_val into field gain_ch (channel index row*COLS+col) of gain_bus, at bits [3*gain_ch +: 3]. The new value is visible after that edge, and all other fields are left unchanged.
- R11: If frame_go is low when a frame ends, no further strobe is issued and the outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_go | input | 1 | Request continuous frame readout |
| gain_we | input | 1 | Gain code write enable |
| gain_ch | input | 7 | Channel index of the gain write |
| gain_val | input | 3 | Gain mode code to write |
| gain_bus | output | 384 | All channel gain codes, 3 bits per channel |
| sh_strobe | output | 1 | Global sample-and-hold strobe |
| drift_rst | output | 1 | Amplifier drift-clearing reset |
| row_sel | output | 3 | Row connected to the column converters |
| conv_start | output | 1 | Start pulse for all column converters |
| conv_done | input | 16 | Per-column conversion done |
| conv_code | input | 128 | Per-column conversion codes, 8 bits each |
| out_valid | output | 1 | Output sample valid |
| out_first | output | 1 | First sample of a frame |
| out_row | output | 3 | Row index of the sample |
| out_col | output | 4 | Column index of the sample |
| out_code | output | 8 | Conversion code of the sample |

## Verification
A converter model in the bench gives each column a latency that varies with frame, row and column. This spreads the conv_done pulses out and reorders them, so a design that loses a late column or files a code under the wrong column is exposed. The expected stream for each row is predicted when that row starts converting and is compared on every valid cycle. Frames are run back to back with a short drift period, which drives frame starts against the drift-reset window and exercises both the R8 schedule and the R9 exclusion. Gain writes to the lowest, highest and a middle channel, followed by a read of a neighbouring field, separate correct indexing from off-by-one or wide writes.

// File: rtl/frs_pkg.sv
package frs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SNAP,
      ST_LAUNCH,
      ST_WAIT,
      ST_EMIT
   } seq_state_t;
endpackage

// File: rtl/frs_gain_bank.sv
module frs_gain_bank #(
   parameter int CHANS     = 128,
   parameter int GAIN_W    = 3,
   parameter int GAIN_INIT = 0,
   localparam int CH_W     = $clog2(CHANS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [CH_W-1:0]          ch,
   input  logic [GAIN_W-1:0]        val,
   output logic [CHANS*GAIN_W-1:0]  bus
);
   if (GAIN_INIT >= (1 << GAIN_W)) begin : g_bad_init
      $error("GAIN_INIT does not fit GAIN_W");
   end

   for (genvar i = 0; i < CHANS; i++) begin : g_ch
      logic [GAIN_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q <= GAIN_W'(GAIN_INIT);
         else if (we && ch == CH_W'(i))
            code_q <= val;
      end
      assign bus[i*GAIN_W +: GAIN_W] = code_q;
   end

   // R10: a write lands in the addressed field on the next cycle
   a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> bus[$past(ch)*GAIN_W +: GAIN_W] == $past(val));
endmodule

// File: rtl/frs_drift_timer.sv
module frs_drift_timer #(
   parameter int PERIOD = 1000,
   parameter int LEN    = 4,
   localparam int CW    = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   output logic drift_rst,
   output logic start_ok
);
   if (LEN < 1 || LEN + 1 >= PERIOD) begin : g_bad_len
      $error("drift pulse length must be at least 1 and below PERIOD-1");
   end

   localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
   localparam logic [CW-1:0] OPEN_AT = CW'(LEN - 1);
   localparam logic [CW-1:0] LEN_C   = CW'(LEN);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign drift_rst = cnt_q < LEN_C;
   // a strobe issued next cycle must land outside the pulse
   assign start_ok  = (cnt_q >= OPEN_AT) && (cnt_q != LAST);

   // R8: wrap of the counter always opens a new reset pulse
   a_r8_wrap_opens: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == LAST |=> drift_rst);
   // R9: permission to start implies the next cycle is free of reset
   a_r9_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> !drift_rst);
endmodule

// File: rtl/frs_col_capture.sv
module frs_col_capture #(
   parameter int COLS   = 16,
   parameter int CODE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic [COLS-1:0]          done,
   input  logic [COLS*CODE_W-1:0]   codes,
   output logic [COLS*CODE_W-1:0]   held,
   output logic                     all_done
);
   logic [COLS-1:0] got_q;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            got_q[c] <= 1'b0;
            code_q   <= '0;
         end else if (clear) begin
            got_q[c] <= 1'b0;
         end else if (done[c]) begin
            got_q[c] <= 1'b1;
            code_q   <= codes[c*CODE_W +: CODE_W];
         end
      end
      assign held[c*CODE_W +: CODE_W] = code_q;
   end

   assign all_done = &got_q;

   // R7: a completed row stays complete until the next launch
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      all_done && !clear |=> all_done);
endmodule

// File: rtl/frame_scan_seq.sv
module frame_scan_seq #(
   parameter int ROWS         = 8,
   parameter int COLS         = 16,
   parameter int CODE_W       = 8,
   parameter int GAIN_W       = 3,
   parameter int GAIN_INIT    = 0,
   parameter int DRIFT_PERIOD = 1000,
   parameter int DRIFT_LEN    = 4,
   localparam int CHANS       = ROWS * COLS,
   localparam int ROW_W       = $clog2(ROWS),
   localparam int COL_W       = $clog2(COLS),
   localparam int CH_W        = $clog2(CHANS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_go,
   input  logic                     gain_we,
   input  logic [CH_W-1:0]          gain_ch,
   input  logic [GAIN_W-1:0]        gain_val,
   output logic [CHANS*GAIN_W-1:0]  gain_bus,
   output logic                     sh_strobe,
   output logic                     drift_rst,
   output logic [ROW_W-1:0]         row_sel,
   output logic                     conv_start,
   input  logic [COLS-1:0]          conv_done,
   input  logic [COLS*CODE_W-1:0]   conv_code,
   output logic                     out_valid,
   output logic                     out_first,
   output logic [ROW_W-1:0]         out_row,
   output logic [COL_W-1:0]         out_col,
   output logic [CODE_W-1:0]        out_code
);
   import frs_pkg::*;

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("array needs at least two rows and two columns");
   end

   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

   seq_state_t             state_q;
   logic [ROW_W-1:0]       row_q;
   logic [COL_W-1:0]       col_q;
   logic                   start_ok;
   logic                   all_done;
   logic [COLS*CODE_W-1:0] held;

   frs_gain_bank #(
      .CHANS(CHANS), .GAIN_W(GAIN_W), .GAIN_INIT(GAIN_INIT)
   ) u_gain (
      .clk(clk), .rst_n(rst_n), .we(gain_we), .ch(gain_ch),
      .val(gain_val), .bus(gain_bus)
   );

   frs_drift_timer #(
      .PERIOD(DRIFT_PERIOD), .LEN(DRIFT_LEN)
   ) u_drift (
      .clk(clk), .rst_n(rst_n), .drift_rst(drift_rst), .start_ok(start_ok)
   );

   frs_col_capture #(
      .COLS(COLS), .CODE_W(CODE_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .clear(conv_start), .done(conv_done),
      .codes(conv_code), .held(held), .all_done(all_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:   if (frame_go && start_ok) state_q <= ST_SNAP;
            ST_SNAP: begin
               row_q   <= '0;
               state_q <= ST_LAUNCH;
            end
            ST_LAUNCH: state_q <= ST_WAIT;
            ST_WAIT: if (all_done) begin
               col_q   <= '0;
               state_q <= ST_EMIT;
            end
            ST_EMIT: begin
               col_q <= col_q + 1'b1;
               if (col_q == LAST_COL) begin
                  if (row_q == LAST_ROW) begin
                     state_q <= ST_IDLE;
                  end else begin
                     row_q   <= row_q + 1'b1;
                     state_q <= ST_LAUNCH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sh_strobe  = state_q == ST_SNAP;
   assign conv_start = state_q == ST_LAUNCH;
   assign row_sel    = row_q;
   assign out_valid  = state_q == ST_EMIT;
   assign out_row    = row_q;
   assign out_col    = col_q;
   assign out_code   = held[col_q*CODE_W +: CODE_W];
   assign out_first  = out_valid && row_q == '0 && col_q == '0;

   // R9: capture strobe never inside a drift reset
   a_r9_no_strobe_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      sh_strobe |-> !drift_rst);
   // R2: strobe is a single-cycle pulse
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      sh_strobe |=> !sh_strobe);
   // R3: converter start is a single-cycle pulse
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R4: columns leave one per cycle without gaps
   a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_col != LAST_COL |=> out_valid && out_col == $past(out_col) + 1'b1);
   // R6: no restart before the last sample of the frame
   a_r6_no_early_snap: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_row == LAST_ROW && out_col == LAST_COL) |=> !sh_strobe);
   // R5: frame flag only on the origin sample
   a_r5_first_origin: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid && out_row == '0 && out_col == '0);
endmodule

// File: tb/frame_scan_seq_tb_top.sv
module frame_scan_seq_tb_top;
   localparam int ROWS = 8, COLS = 16, CODE_W = 8, GAIN_W = 3;
   localparam int PER = 60, LEN = 4;
   localparam int CHANS = ROWS * COLS;

   logic clk = 1'b0;
   logic rst_n, frame_go, gain_we;
   logic [6:0] gain_ch;
   logic [GAIN_W-1:0] gain_val;
   logic [CHANS*GAIN_W-1:0] gain_bus;
   logic sh_strobe, drift_rst, conv_start, out_valid, out_first;
   logic [2:0] row_sel, out_row;
   logic [3:0] out_col;
   logic [CODE_W-1:0] out_code;
   logic [COLS-1:0] conv_done;
   logic [COLS*CODE_W-1:0] conv_code;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   int frames = 0, exp_row = ROWS, samples = 0, firsts = 0;
   bit finished = 0, prev_strobe = 0;
   int cd[COLS];
   logic [15:0] expq[$];

   always #5 clk = ~clk;

   frame_scan_seq #(.DRIFT_PERIOD(PER), .DRIFT_LEN(LEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .gain_we(gain_we),
      .gain_ch(gain_ch), .gain_val(gain_val), .gain_bus(gain_bus),
      .sh_strobe(sh_strobe), .drift_rst(drift_rst), .row_sel(row_sel),
      .conv_start(conv_start), .conv_done(conv_done), .conv_code(conv_code),
      .out_valid(out_valid), .out_first(out_first), .out_row(out_row),
      .out_col(out_col), .out_code(out_code)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] code_of(int f, int r, int c);
      return 8'(f * 37 + r * 19 + c * 11 + 3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;
   end

   // reference model and converter model, evaluated once per clock
   initial begin
      conv_done = '0;
      conv_code = '0;
      for (int c = 0; c < COLS; c++) cd[c] = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            chk(drift_rst == ((cyc % PER) < LEN), "R8", "drift_rst", drift_rst, (cyc % PER) < LEN);
            if (sh_strobe) begin
               chk(!drift_rst, "R9", "strobe during drift reset", 1, 0);
               chk(!prev_strobe, "R2", "strobe width", 2, 1);
               chk(frame_go, "R2", "strobe without frame_go", 0, 1);
               chk(exp_row >= ROWS && expq.size() == 0, "R6", "strobe inside open frame", exp_row, ROWS);
               frames++;
               exp_row = 0;
            end
            prev_strobe = sh_strobe;
            // converter done pulses
            for (int c = 0; c < COLS; c++) begin
               conv_done[c] = 1'b0;
               if (cd[c] > 0) begin
                  cd[c]--;
                  if (cd[c] == 0) begin
                     conv_done[c] = 1'b1;
                     conv_code[c*CODE_W +: CODE_W] = code_of(frames, int'(row_sel), c);
                  end
               end
            end
            if (conv_start) begin
               chk(exp_row < ROWS, "R3", "start outside frame", exp_row, 0);
               chk(int'(row_sel) == exp_row, "R3", "row_sel order", row_sel, exp_row);
               for (int c = 0; c < COLS; c++) begin
                  // R7: uneven, frame-dependent latencies reorder the done pulses
                  cd[c] = 1 + ((c * 3 + exp_row + frames * 2) % 5);
                  expq.push_back({exp_row[2:0], c[3:0], code_of(frames, exp_row, c), 1'b0});
               end
               exp_row++;
            end
            if (out_valid) begin
               samples++;
               if (out_first) firsts++;
               if (expq.size() == 0) begin
                  chk(0, "R4", "unexpected sample", 1, 0);
               end else begin
                  logic [15:0] e;
                  e = expq.pop_front();
                  chk(out_row == e[15:13], "R4", "out_row", out_row, e[15:13]);
                  chk(out_col == e[12:9], "R4", "out_col", out_col, e[12:9]);
                  chk(out_code == e[8:1], "R7", "out_code", out_code, e[8:1]);
                  chk(out_first == (e[15:13] == 0 && e[12:9] == 0), "R5", "out_first",
                      out_first, e[15:13] == 0 && e[12:9] == 0);
               end
            end
         end
      end
   end

   task automatic wr_gain(input int ch, input int v);
      @(negedge clk);
      gain_we = 1'b1; gain_ch = 7'(ch); gain_val = 3'(v);
      @(negedge clk);
      gain_we = 1'b0;
      chk(gain_bus[ch*3 +: 3] == 3'(v), "R10", "gain field written", gain_bus[ch*3 +: 3], v);
   endtask

   initial begin
      int nz;
      rst_n = 1'b0; frame_go = 1'b0; gain_we = 1'b0; gain_ch = '0; gain_val = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!sh_strobe && !conv_start && !out_valid, "R1", "idle outputs in reset",
          {sh_strobe, conv_start, out_valid}, 0);
      chk(gain_bus == '0, "R1", "gain bus reset", gain_bus == '0, 1);
      chk(drift_rst, "R1", "drift reset during reset", drift_rst, 1);
      rst_n = 1'b1;
      // R11 no strobe while frame_go low
      repeat (20) @(negedge clk);
      chk(frames == 0, "R11", "strobe with frame_go low", frames, 0);
      // R10 gain writes
      wr_gain(0, 5);
      wr_gain(127, 7);
      wr_gain(37, 3);
      chk(gain_bus[36*3 +: 3] == 3'd0, "R10", "neighbour field 36", gain_bus[36*3 +: 3], 0);
      chk(gain_bus[38*3 +: 3] == 3'd0, "R10", "neighbour field 38", gain_bus[38*3 +: 3], 0);
      nz = 0;
      for (int i = 0; i < CHANS; i++) if (gain_bus[i*3 +: 3] != 0) nz++;
      chk(nz == 3, "R10", "written field count", nz, 3);
      // back-to-back frames
      frame_go = 1'b1;
      while (frames < 3) @(negedge clk);
      frame_go = 1'b0;
      repeat (600) @(negedge clk);
      chk(frames == 3, "R11", "frames after frame_go drop", frames, 3);
      chk(samples == 3 * CHANS, "R4", "sample total", samples, 3 * CHANS);
      chk(firsts == 3, "R5", "frame flags", firsts, 3);
      chk(expq.size() == 0, "R6", "pending expected samples", expq.size(), 0);
      chk(exp_row == ROWS, "R3", "rows per frame", exp_row, ROWS);
      chk(gain_bus[127*3 +: 3] == 3'd7, "R10", "gain kept across frames", gain_bus[127*3 +: 3], 7);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule